// File: doc/BRIEF.md
# Key-Unlocked Banked Configuration Port

This block holds the configuration registers of a multi-function I/O controller and is reached over a byte-wide host I/O bus. It answers at two neighbouring addresses: an index port at the base address (0x3F0 by default) and a data port one above it (0x3F1). The host unlocks it by writing an entry key to the index port. While unlocked, a byte written to the index port picks a register and the data port reads or writes that register. A byte of the exit key written to the index port locks it again.

One global register, the logical device number, picks which per-device bank the upper part of the index space reaches. The same index can therefore reach different storage. Each bank holds an enable bit, two 16-bit base addresses, two interrupt selects and two address-decoder control bytes. The enable bit, the base addresses and the interrupt selects of every device leave the block on flat output vectors, so that downstream device logic can use them. Two read-only registers report a fixed chip identifier and a revision.

Top module: `ldev_cfg_port`

## Requirements
- R1: After reset the block is locked, the index, the device number, every bank register and every export are 0x00, and the read-data output is 0x00.
- R2: While locked, writing 0x55 to the index port unlocks the block. Any other index-port write, and every data-port write, changes nothing. A read of either port returns 0xFF.
- R3: While unlocked, writing 0xAA to the index port locks the block. Any other byte written there, 0x55 included, becomes the current index. A read of the index port returns the current index.
- R4: Index 0x20 reads 0x30 and index 0x21 reads 0x01. Writes to them have no effect.
- R5: Index 0x07 is the device-number register and can be read and written. With a device number of NUM_DEV or above (9 by default), per-device writes are ignored and per-device reads return 0x00.
- R6: Index 0x30 of the selected bank stores bit 0 of the written byte and reads back as {7'b0, bit}. Device d drives devActive[d].
- R7: Indices 0x60/0x61 hold the high and low bytes of the primary base address, and 0x62/0x63 hold those of the secondary base address. Device d drives devPrimBase[16d+15:16d] and devSecBase[16d+15:16d].
- R8: Index 0x70 is the primary interrupt select and 0x72 the secondary, driving devPrimIrq[8d+7:8d] and devSecIrq[8d+7:8d]. Index 0x71, and any other index with no register, reads 0x00 and ignores writes.
- R9: Indices 0xF0 and 0xF1 are per-device decoder control bytes that can be read back.
- R10: A read is registered: ioRdData shows the value one clock after the cycle with ioRd high, then holds until the next read of one of the two ports. When a read and a write hit the same port in the same cycle, the read returns the value from before the write. Accesses to any other address are ignored.
- R11: A write to one bank leaves every other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ioAddr | input | ADDR_W | Host I/O address |
| ioWr | input | 1 | Write strobe, one cycle per write |
| ioRd | input | 1 | Read strobe, one cycle per read |
| ioWrData | input | 8 | Write data |
| ioRdData | output | 8 | Registered read data |
| devActive | output | NUM_DEV | Enable bit of each device |
| devPrimBase | output | 16*NUM_DEV | Primary base address of each device |
| devSecBase | output | 16*NUM_DEV | Secondary base address of each device |
| devPrimIrq | output | 8*NUM_DEV | Primary interrupt select of each device |
| devSecIrq | output | 8*NUM_DEV | Secondary interrupt select of each device |

## Verification
A read and a write can land on the same port in the same clock. On the data port, the read must return the register's old contents while the new byte is stored. On the index port, the read must return the old index while the new one is latched. The bench forces both strobes high in a single cycle on each port. It then checks the captured byte against the pre-write value and reads again to confirm that the write took effect. A behavioural model running alongside compares the read data and every export on every clock.

// File: rtl/ldev_cfg_pkg.sv
package ldev_cfg_pkg;

  localparam logic [7:0] KEY_ENTER   = 8'h55;
  localparam logic [7:0] KEY_EXIT    = 8'hAA;

  localparam logic [7:0] IDX_DEVNUM  = 8'h07;
  localparam logic [7:0] IDX_CHIPID  = 8'h20;
  localparam logic [7:0] IDX_CHIPREV = 8'h21;
  localparam logic [7:0] CHIP_ID     = 8'h30;
  localparam logic [7:0] CHIP_REV    = 8'h01;

  localparam logic [7:0] IDX_ENABLE  = 8'h30;
  localparam logic [7:0] IDX_PB_HI   = 8'h60;
  localparam logic [7:0] IDX_PB_LO   = 8'h61;
  localparam logic [7:0] IDX_SB_HI   = 8'h62;
  localparam logic [7:0] IDX_SB_LO   = 8'h63;
  localparam logic [7:0] IDX_P_IRQ   = 8'h70;
  localparam logic [7:0] IDX_S_IRQ   = 8'h72;
  localparam logic [7:0] IDX_DEC0    = 8'hF0;
  localparam logic [7:0] IDX_DEC1    = 8'hF1;

  typedef enum logic {MODE_RUN = 1'b0, MODE_CFG = 1'b1} cfgMode_e;

  // control -> datapath
  typedef struct packed {
    logic       cfgOn;   // unlocked
    logic       wrData;  // data-port write while unlocked
    logic       rdIdx;   // index-port read
    logic       rdData;  // data-port read
    logic [7:0] idx;     // current index (pre-write value)
    logic [7:0] devNum;  // current device number (pre-write value)
  } cfgStrobe_t;

endpackage

// File: rtl/ldev_cfg_ctrl.sv
module ldev_cfg_ctrl
  import ldev_cfg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [7:0]        ioWrData,
  output cfgStrobe_t        strb
);

  localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + 1'b1;

  cfgMode_e   modeQ;
  logic [7:0] idxQ;
  logic [7:0] devNumQ;
  logic       hitIdx;
  logic       hitData;

  assign hitIdx  = (ioAddr == BASE_ADDR);
  assign hitData = (ioAddr == DATA_ADDR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ   <= MODE_RUN;
      idxQ    <= 8'h00;
      devNumQ <= 8'h00;
    end else begin
      if (ioWr && hitIdx) begin
        if (modeQ == MODE_RUN) begin
          if (ioWrData == KEY_ENTER) modeQ <= MODE_CFG;
        end else if (ioWrData == KEY_EXIT) begin
          modeQ <= MODE_RUN;
        end else begin
          idxQ <= ioWrData;
        end
      end
      if (ioWr && hitData && modeQ == MODE_CFG && idxQ == IDX_DEVNUM)
        devNumQ <= ioWrData;
    end
  end

  always_comb begin
    strb.cfgOn  = (modeQ == MODE_CFG);
    strb.wrData = ioWr && hitData && (modeQ == MODE_CFG);
    strb.rdIdx  = ioRd && hitIdx;
    strb.rdData = ioRd && hitData;
    strb.idx    = idxQ;
    strb.devNum = devNumQ;
  end

endmodule

// File: rtl/ldev_cfg_bank.sv
module ldev_cfg_bank
  import ldev_cfg_pkg::*;
#(
  parameter int NUM_DEV = 9
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  cfgStrobe_t           strb,
  input  logic [7:0]           ioWrData,
  output logic [7:0]           ioRdData,
  output logic [NUM_DEV-1:0]   devActive,
  output logic [16*NUM_DEV-1:0] devPrimBase,
  output logic [16*NUM_DEV-1:0] devSecBase,
  output logic [8*NUM_DEV-1:0]  devPrimIrq,
  output logic [8*NUM_DEV-1:0]  devSecIrq
);

  logic [8*NUM_DEV-1:0] devRdFlat;
  logic [7:0]           regVal;

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    logic       enQ;
    logic [7:0] pbHi, pbLo, sbHi, sbLo, pIrq, sIrq, dec0, dec1;
    logic       selWr;
    logic [7:0] rv;

    assign selWr = strb.wrData && (strb.devNum == 8'(d));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enQ  <= 1'b0;
        pbHi <= '0; pbLo <= '0; sbHi <= '0; sbLo <= '0;
        pIrq <= '0; sIrq <= '0; dec0 <= '0; dec1 <= '0;
      end else if (selWr) begin
        case (strb.idx)
          IDX_ENABLE: enQ  <= ioWrData[0];
          IDX_PB_HI:  pbHi <= ioWrData;
          IDX_PB_LO:  pbLo <= ioWrData;
          IDX_SB_HI:  sbHi <= ioWrData;
          IDX_SB_LO:  sbLo <= ioWrData;
          IDX_P_IRQ:  pIrq <= ioWrData;
          IDX_S_IRQ:  sIrq <= ioWrData;
          IDX_DEC0:   dec0 <= ioWrData;
          IDX_DEC1:   dec1 <= ioWrData;
          default: ;
        endcase
      end
    end

    always_comb begin
      case (strb.idx)
        IDX_ENABLE: rv = {7'b0, enQ};
        IDX_PB_HI:  rv = pbHi;
        IDX_PB_LO:  rv = pbLo;
        IDX_SB_HI:  rv = sbHi;
        IDX_SB_LO:  rv = sbLo;
        IDX_P_IRQ:  rv = pIrq;
        IDX_S_IRQ:  rv = sIrq;
        IDX_DEC0:   rv = dec0;
        IDX_DEC1:   rv = dec1;
        default:    rv = 8'h00;
      endcase
    end

    assign devRdFlat[8*d +: 8]     = rv;
    assign devActive[d]            = enQ;
    assign devPrimBase[16*d +: 16] = {pbHi, pbLo};
    assign devSecBase[16*d +: 16]  = {sbHi, sbLo};
    assign devPrimIrq[8*d +: 8]    = pIrq;
    assign devSecIrq[8*d +: 8]     = sIrq;
  end

  always_comb begin
    regVal = 8'h00;
    case (strb.idx)
      IDX_DEVNUM:  regVal = strb.devNum;
      IDX_CHIPID:  regVal = CHIP_ID;
      IDX_CHIPREV: regVal = CHIP_REV;
      default: begin
        for (int d = 0; d < NUM_DEV; d++)
          if (strb.devNum == 8'(d)) regVal = devRdFlat[8*d +: 8];
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             ioRdData <= 8'h00;
    else if (strb.rdIdx)   ioRdData <= strb.cfgOn ? strb.idx : 8'hFF;
    else if (strb.rdData)  ioRdData <= strb.cfgOn ? regVal   : 8'hFF;
  end

endmodule

// File: rtl/ldev_cfg_port.sv
module ldev_cfg_port
  import ldev_cfg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0,
  parameter int NUM_DEV = 9
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     ioAddr,
  input  logic                  ioWr,
  input  logic                  ioRd,
  input  logic [7:0]            ioWrData,
  output logic [7:0]            ioRdData,
  output logic [NUM_DEV-1:0]    devActive,
  output logic [16*NUM_DEV-1:0] devPrimBase,
  output logic [16*NUM_DEV-1:0] devSecBase,
  output logic [8*NUM_DEV-1:0]  devPrimIrq,
  output logic [8*NUM_DEV-1:0]  devSecIrq
);

  cfgStrobe_t strb;
  logic       cfgMode;
  logic [7:0] curIndex;

  assign cfgMode  = strb.cfgOn;
  assign curIndex = strb.idx;

  ldev_cfg_ctrl #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd),
    .ioWrData(ioWrData), .strb(strb)
  );

  ldev_cfg_bank #(.NUM_DEV(NUM_DEV)) u_bank (
    .clk(clk), .rstN(rstN), .strb(strb), .ioWrData(ioWrData),
    .ioRdData(ioRdData), .devActive(devActive), .devPrimBase(devPrimBase),
    .devSecBase(devSecBase), .devPrimIrq(devPrimIrq), .devSecIrq(devSecIrq)
  );

endmodule

// File: rtl/ldev_cfg_checker.sv
module ldev_cfg_checker
  import ldev_cfg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0,
  parameter int NUM_DEV = 9
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [ADDR_W-1:0]     ioAddr,
  input logic                  ioWr,
  input logic                  ioRd,
  input logic [7:0]            ioWrData,
  input logic [7:0]            ioRdData,
  input logic                  cfgMode,
  input logic [7:0]            curIndex,
  input logic [NUM_DEV-1:0]    devActive,
  input logic [16*NUM_DEV-1:0] devPrimBase,
  input logic [16*NUM_DEV-1:0] devSecBase,
  input logic [8*NUM_DEV-1:0]  devPrimIrq,
  input logic [8*NUM_DEV-1:0]  devSecIrq
);

  localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + 1'b1;

  logic atIdx, atData, enterWr;
  assign atIdx   = (ioAddr == BASE_ADDR);
  assign atData  = (ioAddr == DATA_ADDR);
  assign enterWr = ioWr && atIdx && (ioWrData == KEY_ENTER);

  AST_ENTER_KEY: assert property (@(posedge clk) disable iff (!rstN)
    !cfgMode && enterWr |=> cfgMode); // R2

  AST_RUN_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    !cfgMode && !enterWr |=> !cfgMode); // R2

  AST_RUN_READ_FF: assert property (@(posedge clk) disable iff (!rstN)
    !cfgMode && ioRd && (atIdx || atData) |=> ioRdData == 8'hFF); // R2

  AST_RUN_EXPORTS_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !cfgMode |=> $stable(devActive) && $stable(devPrimBase) && $stable(devSecBase)
                 && $stable(devPrimIrq) && $stable(devSecIrq)); // R2

  AST_EXIT_KEY: assert property (@(posedge clk) disable iff (!rstN)
    cfgMode && ioWr && atIdx && ioWrData == KEY_EXIT |=> !cfgMode); // R3

  AST_INDEX_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    cfgMode && ioWr && atIdx && ioWrData != KEY_EXIT |=> curIndex == $past(ioWrData)); // R3

  AST_CHIP_ID_READ: assert property (@(posedge clk) disable iff (!rstN)
    cfgMode && ioRd && atData && curIndex == IDX_CHIPID |=> ioRdData == CHIP_ID); // R4

  AST_RDDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ioRd |=> $stable(ioRdData)); // R10

endmodule

bind ldev_cfg_port ldev_cfg_checker #(
  .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NUM_DEV(NUM_DEV)
) u_chk (
  .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd),
  .ioWrData(ioWrData), .ioRdData(ioRdData), .cfgMode(cfgMode),
  .curIndex(curIndex), .devActive(devActive), .devPrimBase(devPrimBase),
  .devSecBase(devSecBase), .devPrimIrq(devPrimIrq), .devSecIrq(devSecIrq)
);

// File: tb/test_ldev_cfg_port.sv
module test_ldev_cfg_port;

  localparam int ND = 9;
  localparam logic [15:0] IDXP = 16'h03F0;
  localparam logic [15:0] DATP = 16'h03F1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] ioAddr = 16'h0000;
  logic ioWr = 1'b0, ioRd = 1'b0;
  logic [7:0] ioWrData = 8'h00;
  logic [7:0] ioRdData;
  logic [ND-1:0] devActive;
  logic [16*ND-1:0] devPrimBase, devSecBase;
  logic [8*ND-1:0] devPrimIrq, devSecIrq;

  int compared = 0, mismatched = 0;
  bit running = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  ldev_cfg_port i_ldev_cfg_port (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd),
    .ioWrData(ioWrData), .ioRdData(ioRdData), .devActive(devActive),
    .devPrimBase(devPrimBase), .devSecBase(devSecBase),
    .devPrimIrq(devPrimIrq), .devSecIrq(devSecIrq)
  );

  // ---------------- behavioural reference ----------------
  int         mLocked;
  logic [7:0] mIdx, mDev, mRd;
  logic [7:0] mReg [0:ND-1][0:255];

  function automatic bit hasReg(input logic [7:0] i);
    return i == 8'h30 || i == 8'h60 || i == 8'h61 || i == 8'h62 || i == 8'h63 ||
           i == 8'h70 || i == 8'h72 || i == 8'hF0 || i == 8'hF1;
  endfunction

  function automatic logic [7:0] mRead(input logic [7:0] i);
    if (i == 8'h07) return mDev;
    if (i == 8'h20) return 8'h30;
    if (i == 8'h21) return 8'h01;
    if (hasReg(i) && int'(mDev) < ND) return mReg[int'(mDev)][i];
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mLocked = 1; mIdx = 0; mDev = 0; mRd = 0;
      for (int d = 0; d < ND; d++)
        for (int i = 0; i < 256; i++) mReg[d][i] = 8'h00;
    end else begin
      logic [7:0] nextRd;
      nextRd = mRd;
      if (ioRd && ioAddr == IDXP) nextRd = mLocked ? 8'hFF : mIdx;
      if (ioRd && ioAddr == DATP) nextRd = mLocked ? 8'hFF : mRead(mIdx);
      if (ioWr && ioAddr == IDXP) begin
        if (mLocked) begin
          if (ioWrData == 8'h55) mLocked = 0;
        end else if (ioWrData == 8'hAA) mLocked = 1;
        else mIdx = ioWrData;
      end else if (ioWr && ioAddr == DATP && !mLocked) begin
        if (mIdx == 8'h07) mDev = ioWrData;
        else if (hasReg(mIdx) && int'(mDev) < ND)
          mReg[int'(mDev)][mIdx] = (mIdx == 8'h30) ? {7'b0, ioWrData[0]} : ioWrData;
      end
      mRd = nextRd;
    end
  end

  task automatic chk(input logic [159:0] act, input logic [159:0] exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      logic [ND-1:0] eAct;
      logic [16*ND-1:0] ePb, eSb;
      logic [8*ND-1:0] ePi, eSi;
      for (int d = 0; d < ND; d++) begin
        eAct[d] = mReg[d][8'h30][0];
        ePb[16*d +: 16] = {mReg[d][8'h60], mReg[d][8'h61]};
        eSb[16*d +: 16] = {mReg[d][8'h62], mReg[d][8'h63]};
        ePi[8*d +: 8] = mReg[d][8'h70];
        eSi[8*d +: 8] = mReg[d][8'h72];
      end
      chk(160'(ioRdData), 160'(mRd), "R10 model rdData");
      chk(160'(devActive), 160'(eAct), "R6 model devActive");
      chk(160'(devPrimBase), 160'(ePb), "R7 model devPrimBase");
      chk(160'(devSecBase), 160'(eSb), "R7 model devSecBase");
      chk(160'(devPrimIrq), 160'(ePi), "R8 model devPrimIrq");
      chk(160'(devSecIrq), 160'(eSi), "R8 model devSecIrq");
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wrPort(input logic [15:0] a, input logic [7:0] v);
    @(negedge clk); ioAddr = a; ioWrData = v; ioWr = 1'b1;
    @(negedge clk); ioWr = 1'b0;
  endtask

  task automatic rdPort(input logic [15:0] a, output logic [7:0] v);
    @(negedge clk); ioAddr = a; ioRd = 1'b1;
    @(negedge clk); ioRd = 1'b0; v = ioRdData;
  endtask

  task automatic cfgWr(input logic [7:0] i, input logic [7:0] v);
    wrPort(IDXP, i); wrPort(DATP, v);
  endtask

  task automatic cfgRd(input logic [7:0] i, output logic [7:0] v);
    wrPort(IDXP, i); rdPort(DATP, v);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    running = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(160'(ioRdData), 160'h0, "R1 rdData after reset");
    chk(160'(devPrimBase), 160'h0, "R1 exports after reset");

    // R2 locked behaviour
    rdPort(DATP, v);           chk(160'(v), 160'hFF, "R2 locked data read");
    rdPort(IDXP, v);           chk(160'(v), 160'hFF, "R2 locked index read");
    wrPort(IDXP, 8'h07);
    wrPort(DATP, 8'h04);
    wrPort(IDXP, 8'hAA);
    wrPort(IDXP, 8'h55);       // unlock
    rdPort(IDXP, v);           chk(160'(v), 160'h00, "R2 locked index write ignored");
    cfgRd(8'h07, v);           chk(160'(v), 160'h00, "R2 locked data write ignored");

    // R4 identity
    cfgRd(8'h20, v);           chk(160'(v), 160'h30, "R4 chip id");
    cfgRd(8'h21, v);           chk(160'(v), 160'h01, "R4 chip rev");
    cfgWr(8'h20, 8'h77);
    cfgRd(8'h20, v);           chk(160'(v), 160'h30, "R4 chip id write ignored");

    // R5 device select, R6..R9 bank registers of device 4
    cfgWr(8'h07, 8'h04);
    cfgRd(8'h07, v);           chk(160'(v), 160'h04, "R5 device number readback");
    cfgWr(8'h30, 8'hFF);
    cfgRd(8'h30, v);           chk(160'(v), 160'h01, "R6 enable reads bit 0");
    chk(160'(devActive), 160'h10, "R6 devActive export");
    cfgWr(8'h60, 8'h03); cfgWr(8'h61, 8'hF8);
    cfgWr(8'h62, 8'h02); cfgWr(8'h63, 8'hFE);
    chk(160'(devPrimBase[64 +: 16]), 160'h03F8, "R7 primary base export");
    chk(160'(devSecBase[64 +: 16]), 160'h02FE, "R7 secondary base export");
    cfgWr(8'h70, 8'h05); cfgWr(8'h72, 8'h0C); cfgWr(8'h71, 8'h99);
    chk(160'(devPrimIrq[32 +: 8]), 160'h05, "R8 primary irq export");
    chk(160'(devSecIrq[32 +: 8]), 160'h0C, "R8 secondary irq export");
    cfgRd(8'h71, v);           chk(160'(v), 160'h00, "R8 hole index reads zero");
    cfgWr(8'hF0, 8'h0C); cfgWr(8'hF1, 8'h3A);
    cfgRd(8'hF0, v);           chk(160'(v), 160'h0C, "R9 decoder 0 readback");
    cfgRd(8'hF1, v);           chk(160'(v), 160'h3A, "R9 decoder 1 readback");

    // R11 bank isolation
    cfgWr(8'h07, 8'h01);
    cfgRd(8'h30, v);           chk(160'(v), 160'h00, "R11 other bank untouched");
    cfgWr(8'h60, 8'h01); cfgWr(8'h61, 8'hF0);
    chk(160'(devPrimBase[64 +: 16]), 160'h03F8, "R11 device 4 base kept");
    chk(160'(devPrimBase[16 +: 16]), 160'h01F0, "R11 device 1 base written");

    // R5 out-of-range device number
    cfgWr(8'h07, 8'h09);
    cfgWr(8'h30, 8'h01);
    cfgRd(8'h30, v);           chk(160'(v), 160'h00, "R5 out-of-range read zero");
    chk(160'(devActive), 160'h10, "R5 out-of-range write ignored");

    // R10 read/write collision on the data port
    cfgWr(8'h07, 8'h04);
    wrPort(IDXP, 8'h61);
    @(negedge clk); ioAddr = DATP; ioWrData = 8'h11; ioWr = 1'b1; ioRd = 1'b1;
    @(negedge clk); ioWr = 1'b0; ioRd = 1'b0;
    chk(160'(ioRdData), 160'hF8, "R10 collision returns old data");
    rdPort(DATP, v);           chk(160'(v), 160'h11, "R10 collision write stored");
    // collision on the index port
    @(negedge clk); ioAddr = IDXP; ioWrData = 8'h63; ioWr = 1'b1; ioRd = 1'b1;
    @(negedge clk); ioWr = 1'b0; ioRd = 1'b0;
    chk(160'(ioRdData), 160'h61, "R10 collision returns old index");
    repeat (3) @(negedge clk);
    chk(160'(ioRdData), 160'h61, "R10 read data holds");
    rdPort(16'h03F2, v);       chk(160'(v), 160'h61, "R10 foreign address ignored");

    // R3 index behaviour and exit
    rdPort(IDXP, v);           chk(160'(v), 160'h63, "R3 index port reads index");
    wrPort(IDXP, 8'h55);
    rdPort(IDXP, v);           chk(160'(v), 160'h55, "R3 enter key is an index when unlocked");
    wrPort(IDXP, 8'h63);
    wrPort(IDXP, 8'hAA);
    rdPort(DATP, v);           chk(160'(v), 160'hFF, "R3 locked after exit key");
    wrPort(DATP, 8'h00);
    chk(160'(devSecBase[64 +: 16]), 160'h02FE, "R2 data write ignored after exit");

    repeat (2) @(negedge clk);
    done = 1'b1;
    running = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule